// File: doc/BRIEF.md
# Smart Card Session Sequencer

This block runs one contact smart card session for a card reader. A host raises a start bit to power up the card and lowers it to end the session. The block then steps the card supply, the I/O driver, the card clock and the card reset line through a fixed power-up order, and through the reverse order on the way down. It watches three hardware fault flags (supply drop, over-current, over-temperature) and the card-presence input. Any of these during a session starts an emergency power-down without waiting for the host. Each new fault also raises a host interrupt.

While a session is up the host can ask for a warm reset. The block then holds the card reset low for a fixed number of card clock ticks and releases it. After each reset release, whether at the end of power-up or after a warm reset, the block watches the card I/O line. The card either starts answering or is declared mute. Either outcome clears the warm reset bit. A low-power mode can be entered only while the card is fully powered down and the start bit is low.

Top module: `card_session_ctrl`

## Requirements
- R1: While `rst` is high, `status` reads 0x04, the card supply, I/O and clock enables are 0, `card_rst_n` is 0 and `irq` is 0. Status bits: bit0 session fully up, bit1 warm reset busy, bit2 idle (fully down), bit3 card mute, bit4 a supply, over-current or temperature flag is set, bit5 card present, bit6 low-power mode, bit7 card answer seen. The status register lags its sources by one clock.
- R2: A rising edge of `ctl_start` is accepted only when the block is idle, the card is present and all fault flags are clear. The supply enable rises at the first clock edge. The I/O enable, the clock enable and `card_rst_n` follow in that order, STEP_CYC clocks apart.
- R3: Lowering `ctl_start` during a session pulls `card_rst_n` low at the next clock edge. The card clock, the I/O enable and the supply enable then switch off in that order, STEP_CYC clocks apart.
- R4: Any fault flag, or card removal, during a session starts the same reverse sequence at the next edge, and `ctl_start` plays no part.
- R5: A one-clock `ctl_warm_req` pulse while the session is fully up holds `card_rst_n` low for exactly WARM_LEN clocks on which `cclk_tick` is high. Status bit1 stays set from the request until the answer or mute outcome.
- R6: After each reset release, a falling edge on `card_io_in` within ANS_WIN card clock ticks sets the answer bit and clears the warm reset bit.
- R7: If no falling edge arrives within ANS_WIN ticks after reset release, the mute bit is set at the ANS_WIN-th tick and the warm reset bit is cleared.
- R8: A new fault event (a flag rising, or card removal during a session) sets `irq`. It stays set until a `stat_rd` pulse.
- R9: A start edge while a fault flag is set or the card is absent is ignored: the supply enable stays off.
- R10: `pd_mode` follows `pd_req` only while the block is idle and `ctl_start` is low. During a session it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_start | input | 1 | Host session start/stop bit |
| ctl_warm_req | input | 1 | One-clock warm reset request |
| stat_rd | input | 1 | Status read strobe, clears irq |
| card_present | input | 1 | Card detected in the slot |
| flt_vdd | input | 1 | Digital supply drop flag |
| flt_vcc | input | 1 | Card supply drop flag |
| flt_ovc | input | 1 | Card over-current flag |
| flt_temp | input | 1 | Over-temperature flag |
| pd_req | input | 1 | Low-power mode request |
| cclk_tick | input | 1 | One-clock pulse per card clock cycle |
| card_io_in | input | 1 | Card I/O line level |
| card_vcc_en | output | 1 | Card supply enable |
| card_io_en | output | 1 | Card I/O driver enable |
| card_clk_en | output | 1 | Card clock enable |
| card_rst_n | output | 1 | Card reset, active low |
| pd_mode | output | 1 | Low-power mode active |
| status | output | 8 | Status word |
| irq | output | 1 | Fault interrupt |

## Verification
Sessions are driven in several ways: a normal start and stop, an emergency stop for each of the five fault causes in a random order, and start attempts while a fault is present. Comparing exact edge times for each of the four card outputs separates a wrong step order from a wrong step spacing. The I/O line is held quiet in some runs and falls after a random delay with a gappy card clock in others, which separates answer from mute. A full-length warm reset with a steady card clock pins its length down to the single tick. Requests for low-power mode arrive both while idle and during a session.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
  typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} dir_e;

  // number of power-up steps: supply, I/O, clock, reset release
  localparam int LVL_TOP = 4;

  // status word bit positions
  localparam int ST_ACTIVE = 0;
  localparam int ST_WARM   = 1;
  localparam int ST_IDLE   = 2;
  localparam int ST_MUTE   = 3;
  localparam int ST_FAULT  = 4;
  localparam int ST_PRES   = 5;
  localparam int ST_PD     = 6;
  localparam int ST_ANS    = 7;

  localparam logic [7:0] STAT_RST = 8'h04;
endpackage

// File: rtl/scs_stepper.sv
`timescale 1ns/1ps
module scs_stepper
  import scs_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_up,
  input  logic       go_down,
  output logic [2:0] level,
  output dir_e       dir,
  output logic       top_evt
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [2:0] TOP = 3'(LVL_TOP);

  logic [CW-1:0] cnt;
  logic          step_due;
  logic          abort;

  assign step_due = (dir != DIR_HOLD) && (cnt == CW'(STEP_CYC - 1));
  assign abort    = go_down && (level != 3'd0) && (dir != DIR_DOWN);
  assign top_evt  = !abort && (dir == DIR_UP) && step_due && (level == TOP - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 3'd0;
      dir   <= DIR_HOLD;
      cnt   <= '0;
    end else if (abort) begin
      level <= level - 3'd1;
      cnt   <= '0;
      dir   <= (level == 3'd1) ? DIR_HOLD : DIR_DOWN;
    end else if (go_up && (level == 3'd0) && (dir == DIR_HOLD)) begin
      level <= 3'd1;
      cnt   <= '0;
      dir   <= (TOP == 3'd1) ? DIR_HOLD : DIR_UP;
    end else if (step_due) begin
      cnt <= '0;
      if (dir == DIR_UP) begin
        level <= level + 3'd1;
        if (level + 3'd1 == TOP) dir <= DIR_HOLD;
      end else begin
        level <= level - 3'd1;
        if (level == 3'd1) dir <= DIR_HOLD;
      end
    end else if (dir != DIR_HOLD) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2 R3
  lvl_step_chk: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> ((level == $past(level) + 3'd1) || (level + 3'd1 == $past(level))));
endmodule

// File: rtl/scs_warm_atr.sv
`timescale 1ns/1ps
module scs_warm_atr #(
  parameter int WARM_LEN = 42000,
  parameter int ANS_WIN  = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic warm_req,
  input  logic sess_up,
  input  logic rel_evt,
  input  logic kill,
  input  logic io_in,
  output logic rst_hold,
  output logic warm_bit,
  output logic ans,
  output logic mute
);
  localparam int WW = $clog2(WARM_LEN + 1);
  localparam int AW = $clog2(ANS_WIN + 1);

  logic [WW-1:0] wcnt;
  logic [AW-1:0] acnt;
  logic          io_q;
  logic          win_on;
  logic          fall;

  assign fall = io_q && !io_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      io_q     <= 1'b1;
      rst_hold <= 1'b0;
      warm_bit <= 1'b0;
      win_on   <= 1'b0;
      ans      <= 1'b0;
      mute     <= 1'b0;
      wcnt     <= '0;
      acnt     <= '0;
    end else begin
      io_q <= io_in;
      if (kill) begin
        warm_bit <= 1'b0;
        rst_hold <= 1'b0;
        win_on   <= 1'b0;
      end else if (warm_req && sess_up && !warm_bit) begin
        warm_bit <= 1'b1;
        rst_hold <= 1'b1;
        wcnt     <= '0;
        win_on   <= 1'b0;
        ans      <= 1'b0;
        mute     <= 1'b0;
      end else if (rel_evt) begin
        win_on <= 1'b1;
        acnt   <= '0;
        ans    <= 1'b0;
        mute   <= 1'b0;
      end else if (rst_hold) begin
        if (tick) begin
          if (wcnt == WW'(WARM_LEN - 1)) begin
            rst_hold <= 1'b0;
            win_on   <= 1'b1;
            acnt     <= '0;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
      end else if (win_on) begin
        if (fall) begin
          ans      <= 1'b1;
          win_on   <= 1'b0;
          warm_bit <= 1'b0;
        end else if (tick) begin
          if (acnt == AW'(ANS_WIN - 1)) begin
            mute     <= 1'b1;
            win_on   <= 1'b0;
            warm_bit <= 1'b0;
          end else begin
            acnt <= acnt + AW'(1);
          end
        end
      end
    end
  end

  // R5
  warm_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_hold && !tick && !kill) |=> $stable(wcnt));

  // R6 R7
  ans_mute_chk: assert property (@(posedge clk) disable iff (rst) !(ans && mute));

  // R6 R7
  warm_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(warm_bit) |-> (ans || mute || $past(kill)));
endmodule

// File: rtl/scs_fault_irq.sv
`timescale 1ns/1ps
module scs_fault_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] flags,
  input  logic       present,
  input  logic       in_sess,
  input  logic       rd,
  output logic       flt_any,
  output logic       fault_cond,
  output logic       irq
);
  logic ev;
  logic ev_q;
  logic set;

  assign flt_any    = |flags;
  assign fault_cond = flt_any || !present;
  assign ev         = flt_any || (!present && in_sess);
  assign set        = ev && !ev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q <= 1'b0;
      irq  <= 1'b0;
    end else begin
      ev_q <= ev;
      if (set)     irq <= 1'b1;
      else if (rd) irq <= 1'b0;
    end
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst) (irq && !rd) |=> irq);
endmodule

// File: rtl/card_session_ctrl.sv
`timescale 1ns/1ps
module card_session_ctrl
  import scs_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int WARM_LEN = 42000,
  parameter int ANS_WIN  = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_start,
  input  logic       ctl_warm_req,
  input  logic       stat_rd,
  input  logic       card_present,
  input  logic       flt_vdd,
  input  logic       flt_vcc,
  input  logic       flt_ovc,
  input  logic       flt_temp,
  input  logic       pd_req,
  input  logic       cclk_tick,
  input  logic       card_io_in,
  output logic       card_vcc_en,
  output logic       card_io_en,
  output logic       card_clk_en,
  output logic       card_rst_n,
  output logic       pd_mode,
  output logic [7:0] status,
  output logic       irq
);
  localparam logic [2:0] TOP = 3'(LVL_TOP);

  logic [2:0] level;
  dir_e       dir;
  logic       top_evt;
  logic       start_q;
  logic       start_rise;
  logic       go_up;
  logic       go_down;
  logic       flt_any;
  logic       fault_cond;
  logic       sess_up;
  logic       idle;
  logic       rst_hold;
  logic       warm_bit;
  logic       ans;
  logic       mute;
  logic [7:0] stat_nxt;

  assign start_rise = ctl_start && !start_q;
  assign go_up      = start_rise && !fault_cond;
  assign go_down    = (level != 3'd0) && (!ctl_start || fault_cond);
  assign sess_up    = (level == TOP) && (dir == DIR_HOLD);
  assign idle       = (level == 3'd0) && (dir == DIR_HOLD);

  scs_fault_irq u_fault (
    .clk        (clk),
    .rst        (rst),
    .flags      ({flt_temp, flt_ovc, flt_vcc, flt_vdd}),
    .present    (card_present),
    .in_sess    (level != 3'd0),
    .rd         (stat_rd),
    .flt_any    (flt_any),
    .fault_cond (fault_cond),
    .irq        (irq)
  );

  scs_stepper #(.STEP_CYC(STEP_CYC)) u_step (
    .clk     (clk),
    .rst     (rst),
    .go_up   (go_up),
    .go_down (go_down),
    .level   (level),
    .dir     (dir),
    .top_evt (top_evt)
  );

  scs_warm_atr #(.WARM_LEN(WARM_LEN), .ANS_WIN(ANS_WIN)) u_warm (
    .clk      (clk),
    .rst      (rst),
    .tick     (cclk_tick),
    .warm_req (ctl_warm_req),
    .sess_up  (sess_up),
    .rel_evt  (top_evt),
    .kill     (go_down),
    .io_in    (card_io_in),
    .rst_hold (rst_hold),
    .warm_bit (warm_bit),
    .ans      (ans),
    .mute     (mute)
  );

  // card pins decoded from the registered step level
  assign card_vcc_en = (level >= 3'd1);
  assign card_io_en  = (level >= 3'd2);
  assign card_clk_en = (level >= 3'd3);
  assign card_rst_n  = (level >= TOP) && !rst_hold;

  always_comb begin
    stat_nxt           = '0;
    stat_nxt[ST_ACTIVE] = sess_up;
    stat_nxt[ST_WARM]   = warm_bit;
    stat_nxt[ST_IDLE]   = idle;
    stat_nxt[ST_MUTE]   = mute;
    stat_nxt[ST_FAULT]  = flt_any;
    stat_nxt[ST_PRES]   = card_present;
    stat_nxt[ST_PD]     = pd_mode;
    stat_nxt[ST_ANS]    = ans;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      pd_mode <= 1'b0;
      status  <= STAT_RST;
    end else begin
      start_q <= ctl_start;
      pd_mode <= pd_req && idle && !ctl_start;
      status  <= stat_nxt;
    end
  end

  // R4
  emerg_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_cond && (level != 3'd0)) |=> !card_rst_n);

  // R9
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (start_rise && fault_cond && (level == 3'd0)) |=> !card_vcc_en);

  // R10
  pd_sess_chk: assert property (@(posedge clk) disable iff (rst)
    pd_mode |-> !card_vcc_en);
endmodule

// File: tb/test_card_session_ctrl.sv
`timescale 1ns/1ps
module test_card_session_ctrl;
  localparam int S  = 4;
  localparam int WL = 42000;
  localparam int AW = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_start = 0, ctl_warm_req = 0, stat_rd = 0, card_present = 1;
  logic flt_vdd = 0, flt_vcc = 0, flt_ovc = 0, flt_temp = 0, pd_req = 0;
  logic cclk_tick = 1, card_io_in = 1;
  logic card_vcc_en, card_io_en, card_clk_en, card_rst_n, pd_mode, irq;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  int tt [4];
  bit done = 0;

  always #5 clk = ~clk;

  card_session_ctrl #(.STEP_CYC(S), .WARM_LEN(WL), .ANS_WIN(AW)) i_card_session_ctrl (
    .clk(clk), .rst(rst), .ctl_start(ctl_start), .ctl_warm_req(ctl_warm_req),
    .stat_rd(stat_rd), .card_present(card_present), .flt_vdd(flt_vdd),
    .flt_vcc(flt_vcc), .flt_ovc(flt_ovc), .flt_temp(flt_temp), .pd_req(pd_req),
    .cclk_tick(cclk_tick), .card_io_in(card_io_in), .card_vcc_en(card_vcc_en),
    .card_io_en(card_io_en), .card_clk_en(card_clk_en), .card_rst_n(card_rst_n),
    .pd_mode(pd_mode), .status(status), .irq(irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected cycle of the i-th step, counted from the triggering edge
  function automatic int step_at(input int i);
    return 1 + i * S;
  endfunction

  // record the cycle at which each output reaches its target, in sequence order
  task automatic track(input bit up);
    bit v [4];
    for (int i = 0; i < 4; i++) tt[i] = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (up) begin
        v[0] = card_vcc_en; v[1] = card_io_en; v[2] = card_clk_en; v[3] = card_rst_n;
      end else begin
        v[0] = !card_rst_n; v[1] = !card_clk_en; v[2] = !card_io_en; v[3] = !card_vcc_en;
      end
      for (int i = 0; i < 4; i++) if (tt[i] < 0 && v[i]) tt[i] = k;
      if (tt[3] >= 0) break;
    end
  endtask

  task automatic check_seq(input string req, input string tag);
    for (int i = 0; i < 4; i++) chk(req, $sformatf("%s step %0d cycle", tag, i), tt[i], step_at(i));
  endtask

  task automatic activate(input string tag);
    ctl_start = 1;
    track(1);
    check_seq("R2", tag);
  endtask

  task automatic shut_down(input string tag);
    ctl_start = 0;
    track(0);
    check_seq("R3", tag);
  endtask

  task automatic set_fault(input int f, input logic val);
    case (f)
      0: flt_vdd = val;
      1: flt_vcc = val;
      2: flt_ovc = val;
      3: flt_temp = val;
      default: card_present = !val;
    endcase
  endtask

  task automatic answer_after(input int d, input bit gappy);
    for (int k = 0; k < d; k++) begin
      if (gappy) cclk_tick = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    cclk_tick = 1;
    card_io_in = 0;
    cyc(3);
    card_io_in = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int order [5];
    int d;
    seed = $urandom(32'd7816);
    cyc(5);
    // R1 reset state
    chk("R1", "status in reset", status, 8'h04);
    chk("R1", "vcc in reset", card_vcc_en, 0);
    chk("R1", "rst_n in reset", card_rst_n, 0);
    chk("R1", "irq in reset", irq, 0);
    rst = 0;
    cyc(2);
    chk("R1", "idle status after reset", status, 8'h24);

    // R10 low-power while idle, then ignored during a session
    pd_req = 1;
    cyc(2);
    chk("R10", "pd_mode idle", pd_mode, 1);
    chk("R10", "pd status bit idle", status[6], 1);
    activate("first");
    chk("R10", "pd_mode in session", pd_mode, 0);
    chk("R10", "pd status in session", status[6], 0);
    pd_req = 0;

    // R6 answer with a gappy card clock
    d = $urandom_range(5, 100);
    answer_after(d, 1);
    chk("R6", "answer bit", status[7], 1);
    chk("R6", "mute bit after answer", status[3], 0);
    chk("R2", "session active bit", status[0], 1);

    // R5 warm reset of exact length, then R6 answer
    ctl_warm_req = 1;
    @(negedge clk);
    ctl_warm_req = 0;
    d = 0;
    while (card_rst_n == 1'b0 && d < 50000) begin
      d++;
      if (d == 3) chk("R5", "warm busy bit during pulse", status[1], 1);
      @(negedge clk);
    end
    chk("R5", "warm reset length", d, WL);
    chk("R5", "warm busy bit before answer", status[1], 1);
    answer_after($urandom_range(2, 50), 0);
    chk("R6", "answer after warm", status[7], 1);
    chk("R6", "warm bit cleared by answer", status[1], 0);

    // R7 warm reset followed by silence
    ctl_warm_req = 1;
    @(negedge clk);
    ctl_warm_req = 0;
    while (card_rst_n == 1'b0) @(negedge clk);
    cyc(AW - 1);
    chk("R7", "mute not yet", status[3], 0);
    chk("R7", "warm still busy", status[1], 1);
    cyc(2);
    chk("R7", "mute after window", status[3], 1);
    chk("R7", "warm bit cleared by mute", status[1], 0);

    // R3 host deactivation
    shut_down("host stop");
    cyc(2);
    chk("R3", "idle after stop", status[2], 1);

    // R7 mute right after activation
    activate("mute run");
    cyc(AW - 1);
    chk("R7", "mute not yet after activation", status[3], 0);
    cyc(2);
    chk("R7", "mute after activation window", status[3], 1);
    shut_down("after mute");
    cyc(2);

    // R4 R8 R9 emergency deactivation for each cause, random order
    for (int i = 0; i < 5; i++) order[i] = i;
    for (int i = 4; i > 0; i--) begin
      int j; int t;
      j = $urandom_range(0, i);
      t = order[i]; order[i] = order[j]; order[j] = t;
    end
    for (int n = 0; n < 5; n++) begin
      int f;
      f = order[n];
      activate($sformatf("before fault %0d", f));
      cyc($urandom_range(1, 20));
      set_fault(f, 1);
      track(0);
      check_seq("R4", $sformatf("emergency fault %0d", f));
      chk("R8", $sformatf("irq after fault %0d", f), irq, 1);
      if (f < 4) chk("R1", "fault status bit", status[4], 1);
      else chk("R1", "present status bit", status[5], 0);
      cyc(3);
      chk("R8", "irq held before read", irq, 1);
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      chk("R8", "irq cleared by read", irq, 0);
      ctl_start = 0;
      cyc(2);
      ctl_start = 1;
      cyc(S * 3);
      chk("R9", $sformatf("start refused with fault %0d", f), card_vcc_en, 0);
      ctl_start = 0;
      set_fault(f, 0);
      cyc(3);
    end

    // R2 activation again works once faults are gone
    activate("final");
    shut_down("final");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule